// File: doc/BRIEF.md
# Integer and Precision Format Converter

This block changes the type or the precision of a numeric operand. It turns a signed 32-bit integer into a single precision value and a single precision value back into a signed integer. It also narrows double precision to single precision and widens single precision to double precision. Each request carries a two-bit operation code, a 64-bit operand and a valid strobe. The result and an inexact flag are registered and appear on the clock edge that samples the request.

Single precision and integer operands use only bits 31:0 of the operand. Single precision and integer results sit in bits 31:0 of the result, with bits 63:32 at zero. Both narrowing paths round to nearest with ties to even. Conversion to an integer truncates toward zero and saturates when the value is out of range. Subnormal inputs are read as zero of the same sign. No exception is ever raised, and the only side report is the inexact flag.

Operation codes: 0 converts integer to single, 1 converts single to integer, 2 converts double to single, and 3 converts single to double.

Top module: `fmt_convert`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock edge. `out_result` and `out_inexact` load only on edges where `in_valid` is high and otherwise hold their value.
- R2: While reset is asserted, and until the first accepted request, `out_valid`, `out_result` and `out_inexact` are zero.
- R3: Code 0 converts a two's-complement integer to single precision, with bits 63:32 of the result at zero. Integer 0 gives 0x00000000, -8 gives 0xC1000000, -1 gives 0xBF800000 and 0x80000000 gives 0xCF000000, all with inexact clear.
- R4: Code 0 keeps 24 significant bits and rounds to nearest, ties to even. Inexact is set when any dropped bit is 1. 0x01000001 gives 0x4B800000 and 0x01000003 gives 0x4B800002, both inexact.
- R5: Code 1 converts single precision to a two's-complement integer by truncating toward zero. Inexact is set when any fraction bit is dropped. 0xC0200000 (-2.5) gives 0xFFFFFFFE, 0x3F000000 (0.5) gives 0, and 0x4EFFFFFF gives 0x7FFFFF80 exactly.
- R6: Code 1 saturates with inexact clear. Any NaN gives 0x7FFFFFFF. A positive value at or above 2^31, including infinity, gives 0x7FFFFFFF. A negative value at or below -2^31 gives 0x80000000.
- R7: Code 2 rounds the 52-bit fraction to 23 bits, to nearest with ties to even, and sets inexact when any dropped bit is 1. 0xBFD3333333333333 gives 0xBE99999A.
- R8: Code 2 handles the edges as follows. A finite value too large for single precision, including one that rounds up past the largest finite value, gives infinity with the input's sign and inexact set. A nonzero value below the smallest normal single gives zero with the input's sign and inexact set. Infinity gives infinity with inexact clear. NaN gives 0x7FC00000 with inexact clear.
- R9: Code 3 is exact and never sets inexact. It re-biases the exponent to 11 bits and places the 23 fraction bits at the top of the 52-bit fraction: 0xBE99999A gives 0xBFD3333340000000. A NaN keeps its sign and gets its top fraction bit set.
- R10: Inputs with an all-zero exponent field convert as zero of the same sign, with inexact clear.
- R11: An integer converted to single and back with code 1 comes back with its dropped bits rounded off. 841242345 comes back as 841242368, with inexact set on the first step only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation code (0 int to single, 1 single to int, 2 double to single, 3 single to double) |
| in_opnd | input | 64 | Operand; bits 31:0 only for integer and single sources |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | Converted value |
| out_inexact | output | 1 | Some discarded bit was nonzero |

## Verification
The bench builds the converter with its default widths: a 32-bit integer, an 8-bit exponent with a 23-bit fraction, and an 11-bit exponent with a 52-bit fraction. With these widths, hand-computed bit patterns apply directly, so rounding ties, carries from rounding into the exponent and up to infinity, exponent limits and saturation at the integer limits can all be hit exactly. The round-trip scenario sends a 30-bit integer through two requests to show that the low bits are lost. A hold scenario changes the operand while the strobe is low, to show that the result register ignores it.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  typedef enum logic [1:0] {
    OP_I2S = 2'd0,
    OP_S2I = 2'd1,
    OP_D2S = 2'd2,
    OP_S2D = 2'd3
  } cvt_op_e;

  localparam int INT_W     = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_W      = SP_EXP_W + SP_FRAC_W + 1;
  localparam int DP_W      = DP_EXP_W + DP_FRAC_W + 1;
endpackage

// File: rtl/cvt_int_to_sp.sv
module cvt_int_to_sp #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [INT_W-1:0]        src,
  output logic [EXP_W+FRAC_W:0]   dst,
  output logic                    inexact
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int LZ_W  = $clog2(INT_W);
  localparam int GRD   = INT_W - 2 - FRAC_W;
  localparam int OUT_W = EXP_W + FRAC_W + 1;

  logic             sign;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] norm;
  logic [LZ_W-1:0]  lz;
  logic [EXP_W-1:0] expo;
  logic             guard, sticky, up;

  always_comb begin
    sign = src[INT_W-1];
    mag  = sign ? (~src + 1'b1) : src;
    lz   = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lz = LZ_W'(INT_W - 1 - i);
    end
    norm   = mag << lz;
    expo   = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz);
    guard  = norm[GRD];
    sticky = |norm[GRD-1:0];
    up     = guard & (sticky | norm[GRD+1]);
    if (mag == '0) begin
      dst     = '0;
      inexact = 1'b0;
    end else begin
      dst     = {sign, expo, norm[INT_W-2 -: FRAC_W]} + OUT_W'(up);
      inexact = guard | sticky;
    end
  end
endmodule

// File: rtl/cvt_sp_to_int.sv
module cvt_sp_to_int #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] src,
  output logic [INT_W-1:0]      dst,
  output logic                  inexact
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int EXT_W = FRAC_W + 1 + INT_W;
  localparam int TOP   = FRAC_W + INT_W;
  localparam int SH_W  = $clog2(EXT_W);
  localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MAX_NEG = {1'b1, {(INT_W-1){1'b0}}};

  logic              sign;
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  int                unb;
  logic [EXT_W-1:0]  ext, kept;
  logic [SH_W-1:0]   sh;
  logic [INT_W-1:0]  mag;

  always_comb begin
    sign    = src[EXP_W+FRAC_W];
    e       = src[EXP_W+FRAC_W-1 -: EXP_W];
    f       = src[FRAC_W-1:0];
    unb     = int'(e) - BIAS;
    ext     = {1'b1, f, {INT_W{1'b0}}};
    sh      = '0;
    kept    = '0;
    mag     = '0;
    dst     = '0;
    inexact = 1'b0;
    if (e == '0) begin
      dst = '0;
    end else if (e == '1 && f != '0) begin
      dst = MAX_POS;
    end else if (unb < 0) begin
      inexact = 1'b1;
    end else if (unb >= INT_W - 1) begin
      dst = sign ? MAX_NEG : MAX_POS;
    end else begin
      sh      = SH_W'(TOP - unb);
      kept    = ext >> sh;
      mag     = kept[INT_W-1:0];
      inexact = (kept << sh) != ext;
      dst     = sign ? (~mag + 1'b1) : mag;
    end
  end
endmodule

// File: rtl/cvt_dp_to_sp.sv
module cvt_dp_to_sp #(
  parameter int SRC_EXP_W  = 11,
  parameter int SRC_FRAC_W = 52,
  parameter int DST_EXP_W  = 8,
  parameter int DST_FRAC_W = 23
) (
  input  logic [SRC_EXP_W+SRC_FRAC_W:0] src,
  output logic [DST_EXP_W+DST_FRAC_W:0] dst,
  output logic                          inexact
);
  localparam int SRC_BIAS = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int DST_BIAS = (1 << (DST_EXP_W - 1)) - 1;
  localparam int REBIAS   = SRC_BIAS - DST_BIAS;
  localparam int GRD      = SRC_FRAC_W - DST_FRAC_W - 1;
  localparam int DST_EMAX = (1 << DST_EXP_W) - 1;
  localparam int OUT_W    = DST_EXP_W + DST_FRAC_W + 1;

  logic                  sign;
  logic [SRC_EXP_W-1:0]  e;
  logic [SRC_FRAC_W-1:0] f;
  int                    be;
  logic                  guard, sticky, up;

  always_comb begin
    sign    = src[SRC_EXP_W+SRC_FRAC_W];
    e       = src[SRC_EXP_W+SRC_FRAC_W-1 -: SRC_EXP_W];
    f       = src[SRC_FRAC_W-1:0];
    be      = int'(e) - REBIAS;
    guard   = f[GRD];
    sticky  = |f[GRD-1:0];
    up      = guard & (sticky | f[GRD+1]);
    dst     = '0;
    inexact = 1'b0;
    if (e == '0) begin
      dst = {sign, {(OUT_W-1){1'b0}}};
    end else if (e == '1) begin
      if (f != '0) dst = {1'b0, {DST_EXP_W{1'b1}}, 1'b1, {(DST_FRAC_W-1){1'b0}}};
      else         dst = {sign, {DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};
    end else if (be >= DST_EMAX) begin
      dst     = {sign, {DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};
      inexact = 1'b1;
    end else if (be <= 0) begin
      dst     = {sign, {(OUT_W-1){1'b0}}};
      inexact = 1'b1;
    end else begin
      dst     = {sign, DST_EXP_W'(be), f[SRC_FRAC_W-1 -: DST_FRAC_W]} + OUT_W'(up);
      inexact = guard | sticky;
    end
  end
endmodule

// File: rtl/cvt_sp_to_dp.sv
module cvt_sp_to_dp #(
  parameter int SRC_EXP_W  = 8,
  parameter int SRC_FRAC_W = 23,
  parameter int DST_EXP_W  = 11,
  parameter int DST_FRAC_W = 52
) (
  input  logic [SRC_EXP_W+SRC_FRAC_W:0] src,
  output logic [DST_EXP_W+DST_FRAC_W:0] dst
);
  localparam int SRC_BIAS = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int DST_BIAS = (1 << (DST_EXP_W - 1)) - 1;
  localparam int REBIAS   = DST_BIAS - SRC_BIAS;
  localparam int PAD_W    = DST_FRAC_W - SRC_FRAC_W;
  localparam int OUT_W    = DST_EXP_W + DST_FRAC_W + 1;

  logic                  sign;
  logic [SRC_EXP_W-1:0]  e;
  logic [SRC_FRAC_W-1:0] f;

  always_comb begin
    sign = src[SRC_EXP_W+SRC_FRAC_W];
    e    = src[SRC_EXP_W+SRC_FRAC_W-1 -: SRC_EXP_W];
    f    = src[SRC_FRAC_W-1:0];
    if (e == '0) begin
      dst = {sign, {(OUT_W-1){1'b0}}};
    end else if (e == '1) begin
      dst = {sign, {DST_EXP_W{1'b1}}, (f != '0), f[SRC_FRAC_W-2:0], {PAD_W{1'b0}}};
    end else begin
      dst = {sign, DST_EXP_W'(int'(e) + REBIAS), f, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fmt_convert.sv
module fmt_convert
  import cvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  in_op,
  input  logic [63:0] in_opnd,
  output logic        out_valid,
  output logic [63:0] out_result,
  output logic        out_inexact
);
  localparam int RES_W = DP_W;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  cvt_op_e          op;
  logic [SP_W-1:0]  i2s_res, d2s_res;
  logic [INT_W-1:0] s2i_res;
  logic [DP_W-1:0]  s2d_res;
  logic             i2s_inx, s2i_inx, d2s_inx;
  logic [RES_W-1:0] res_d, res_q;
  logic             inx_d, inx_q, vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cvt_int_to_sp #(.INT_W(INT_W), .EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_i2s (
    .src(in_opnd[INT_W-1:0]), .dst(i2s_res), .inexact(i2s_inx));

  cvt_sp_to_int #(.INT_W(INT_W), .EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_s2i (
    .src(in_opnd[SP_W-1:0]), .dst(s2i_res), .inexact(s2i_inx));

  cvt_dp_to_sp #(.SRC_EXP_W(DP_EXP_W), .SRC_FRAC_W(DP_FRAC_W),
                 .DST_EXP_W(SP_EXP_W), .DST_FRAC_W(SP_FRAC_W)) u_d2s (
    .src(in_opnd[DP_W-1:0]), .dst(d2s_res), .inexact(d2s_inx));

  cvt_sp_to_dp #(.SRC_EXP_W(SP_EXP_W), .SRC_FRAC_W(SP_FRAC_W),
                 .DST_EXP_W(DP_EXP_W), .DST_FRAC_W(DP_FRAC_W)) u_s2d (
    .src(in_opnd[SP_W-1:0]), .dst(s2d_res));

  always_comb begin
    op = cvt_op_e'(in_op);
    unique case (op)
      OP_I2S: begin res_d = RES_W'(i2s_res); inx_d = i2s_inx; end
      OP_S2I: begin res_d = RES_W'(s2i_res); inx_d = s2i_inx; end
      OP_D2S: begin res_d = RES_W'(d2s_res); inx_d = d2s_inx; end
      default: begin res_d = s2d_res;        inx_d = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inx_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        inx_q <= inx_d;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_result  = res_q;
  assign out_inexact = inx_q;
endmodule

// File: rtl/fmt_convert_chk.sv
module fmt_convert_chk
  import cvt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_op,
  input logic [63:0] in_opnd,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic        out_inexact
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_inexact)));

  p_i2s_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_I2S && in_opnd[31:0] == 32'h0) |=> (out_result == 64'h0 && !out_inexact));

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != OP_S2D) |=> (out_result[63:32] == 32'h0));

  p_s2i_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_S2I && in_opnd[30:23] == 8'hFF && in_opnd[22:0] != 23'h0)
    |=> (out_result[31:0] == 32'h7FFFFFFF && !out_inexact));

  p_d2s_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_D2S && in_opnd[62:52] == 11'h7FF && in_opnd[51:0] != 52'h0)
    |=> (out_result[31:0] == 32'h7FC00000));

  p_widen_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_S2D) |=> !out_inexact);

  p_subnorm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_S2D && in_opnd[30:23] == 8'h00)
    |=> (out_result[62:0] == 63'h0 && out_result[63] == $past(in_opnd[31])));
endmodule

bind fmt_convert fmt_convert_chk i_fmt_convert_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_opnd    (in_opnd),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_inexact(out_inexact)
);

// File: tb/test_fmt_convert.sv
`timescale 1ns/1ps
module test_fmt_convert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic [63:0] in_opnd = 64'h0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fmt_convert i_fmt_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_opnd(in_opnd), .out_valid(out_valid), .out_result(out_result),
    .out_inexact(out_inexact));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [1:0] op, input logic [63:0] a,
                      output logic [63:0] r, output logic x, output logic v);
    @(negedge clk);
    in_op = op; in_opnd = a; in_valid = 1'b1;
    @(posedge clk); #1;
    r = out_result; x = out_inexact; v = out_valid;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_conv(input string req, input logic [1:0] op, input logic [63:0] a,
                             input logic [63:0] er, input logic ex);
    logic [63:0] r; logic x, v;
    conv(op, a, r, x, v);
    chk({req, " result"}, r, er);
    chk({req, " inexact"}, {63'h0, x}, {63'h0, ex});
    if (v !== 1'b1) chk({req, " valid R1"}, {63'h0, v}, 64'h1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R2 valid in reset", {63'h0, out_valid}, 64'h0);
    chk("R2 result in reset", out_result, 64'h0);
    chk("R2 inexact in reset", {63'h0, out_inexact}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R2 result after release", out_result, 64'h0);
  endtask

  task automatic t_int_to_single;
    expect_conv("R3 zero", 2'd0, 64'h0, 64'h0, 1'b0);
    expect_conv("R3 minus eight", 2'd0, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0000_0000_C100_0000, 1'b0);
    expect_conv("R3 minus one", 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_BF80_0000, 1'b0);
    expect_conv("R3 most negative", 2'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_CF00_0000, 1'b0);
  endtask

  task automatic t_int_rounding;
    expect_conv("R4 tie to even down", 2'd0, 64'h0100_0001, 64'h4B80_0000, 1'b1);
    expect_conv("R4 tie to even up", 2'd0, 64'h0100_0003, 64'h4B80_0002, 1'b1);
  endtask

  task automatic t_single_to_int;
    expect_conv("R5 minus two and a half", 2'd1, 64'hC020_0000, 64'hFFFF_FFFE, 1'b1);
    expect_conv("R5 one half", 2'd1, 64'h3F00_0000, 64'h0, 1'b1);
    expect_conv("R5 one and a half", 2'd1, 64'h3FC0_0000, 64'h1, 1'b1);
    expect_conv("R5 largest exact", 2'd1, 64'h4EFF_FFFF, 64'h7FFF_FF80, 1'b0);
  endtask

  task automatic t_saturate;
    expect_conv("R6 nan", 2'd1, 64'h7FC0_0000, 64'h7FFF_FFFF, 1'b0);
    expect_conv("R6 two pow 31", 2'd1, 64'h4F00_0000, 64'h7FFF_FFFF, 1'b0);
    expect_conv("R6 minus inf", 2'd1, 64'hFF80_0000, 64'h8000_0000, 1'b0);
    expect_conv("R6 below min", 2'd1, 64'hCF00_0001, 64'h8000_0000, 1'b0);
  endtask

  task automatic t_double_to_single;
    expect_conv("R7 minus point three", 2'd2, 64'hBFD3_3333_3333_3333, 64'hBE99_999A, 1'b1);
    expect_conv("R7 one", 2'd2, 64'h3FF0_0000_0000_0000, 64'h3F80_0000, 1'b0);
  endtask

  task automatic t_double_edges;
    expect_conv("R8 overflow pos", 2'd2, 64'h47F0_0000_0000_0000, 64'h7F80_0000, 1'b1);
    expect_conv("R8 overflow neg", 2'd2, 64'hC7F0_0000_0000_0000, 64'hFF80_0000, 1'b1);
    expect_conv("R8 rounds to inf", 2'd2, 64'h47EF_FFFF_F000_0000, 64'h7F80_0000, 1'b1);
    expect_conv("R8 underflow", 2'd2, 64'hB800_0000_0000_0000, 64'h8000_0000, 1'b1);
    expect_conv("R8 smallest normal", 2'd2, 64'h3810_0000_0000_0000, 64'h0080_0000, 1'b0);
    expect_conv("R8 nan", 2'd2, 64'hFFF0_0000_0000_0001, 64'h7FC0_0000, 1'b0);
    expect_conv("R8 inf", 2'd2, 64'hFFF0_0000_0000_0000, 64'hFF80_0000, 1'b0);
  endtask

  task automatic t_single_to_double;
    expect_conv("R9 widen", 2'd3, 64'hBE99_999A, 64'hBFD3_3333_4000_0000, 1'b0);
    expect_conv("R9 inf", 2'd3, 64'h7F80_0000, 64'h7FF0_0000_0000_0000, 1'b0);
    expect_conv("R9 nan quiet", 2'd3, 64'hFF80_0001, 64'hFFF8_0000_2000_0000, 1'b0);
  endtask

  task automatic t_subnormal;
    expect_conv("R10 widen subnormal", 2'd3, 64'h8000_0001, 64'h8000_0000_0000_0000, 1'b0);
    expect_conv("R10 to int subnormal", 2'd1, 64'h007F_FFFF, 64'h0, 1'b0);
    expect_conv("R10 narrow subnormal", 2'd2, 64'h000F_FFFF_FFFF_FFFF, 64'h0, 1'b0);
  endtask

  task automatic t_round_trip;
    logic [63:0] r1, r2; logic x1, x2, v;
    conv(2'd0, 64'd841242345, r1, x1, v);
    chk("R11 first step inexact", {63'h0, x1}, 64'h1);
    conv(2'd1, r1, r2, x2, v);
    chk("R11 round trip value", r2, 64'd841242368);
    chk("R11 second step exact", {63'h0, x2}, 64'h0);
  endtask

  task automatic t_hold;
    logic [63:0] r; logic x, v;
    conv(2'd0, 64'hFFFF_FFF8, r, x, v);
    @(negedge clk);
    in_valid = 1'b0; in_op = 2'd2; in_opnd = 64'h47F0_0000_0000_0000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid low when idle", {63'h0, out_valid}, 64'h0);
    chk("R1 result held when idle", out_result, 64'h0000_0000_C100_0000);
    chk("R1 inexact held when idle", {63'h0, out_inexact}, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_int_to_single;
    t_int_rounding;
    t_single_to_int;
    t_saturate;
    t_double_to_single;
    t_double_edges;
    t_single_to_double;
    t_subnormal;
    t_round_trip;
    t_hold;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule